// File: doc/BRIEF.md
# Bidirectional Gate Scan Shift Register

This block models the row-select sequencer of a matrix display. A single token walks through a chain of one lead-in (dummy) stage and a configurable number of gate stages. The token advances by one stage for each vertical shift strobe, so one stage moves per horizontal line period. A start pulse, sampled on a strobe, places the token in the first stage of the scan order. A direction input chooses that order. Scanning downward runs dummy, gate 1, and on to the last gate. Scanning upward runs the last gate, down to gate 1, and then the dummy.

Each gate output is qualified by a shared enable pulse. A row is therefore driven only inside the enable window. The registered token is kept while the enable is low. When the token leaves the final stage of the scan order, the block emits a one-cycle frame-done pulse.

The direction is latched at the start pulse. A later change on the direction input does not affect the frame that is running.

Top module: `gate_scan_shifter`

## Requirements
- R1: After reset, the dummy output, every gate output and frame_done_o are low, and no token is held.
- R2: On a clock edge with shift_i and start_i both high, the token is loaded into the first stage of the scan order. If dir_i=1 (downward), that stage is the dummy. If dir_i=0 (upward), it is the last gate, gate_o[N_GATES-1]. Gate k (1-based) drives bit gate_o[k-1].
- R3: At most one of the dummy output and the gate outputs is high at any time.
- R4: The gate outputs and the dummy output are high only while enable_i is high. When enable_i is low, all of them are low and the held token is unaffected.
- R5: On each edge with shift_i high and start_i low, the token moves exactly one stage along the latched scan order. On edges with shift_i low, it holds.
- R6: The direction is captured only at a start. A change of dir_i during a frame does not change the order until the next start.
- R7: On the edge where a shift moves the token out of the final stage of the scan order, frame_done_o goes high for exactly one clock cycle. Afterwards no output is high until the next start.
- R8: A start during a frame discards the running token and restarts from the first stage of the newly selected order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_i | input | 1 | Vertical shift strobe, one cycle per line |
| start_i | input | 1 | Frame start, sampled when shift_i is high |
| dir_i | input | 1 | Scan order: 1 downward, 0 upward |
| enable_i | input | 1 | Output qualification pulse |
| dummy_o | output | 1 | Lead-in stage select |
| gate_o | output | N_GATES | One-hot gate selects, bit k-1 is gate k |
| frame_done_o | output | 1 | One-cycle pulse when the token leaves the chain |

## Verification
The bench builds the block with N_GATES=10, so an 11-stage chain is walked end to end many times within a short run. With a chain this short, random start, strobe, direction and enable patterns repeatedly reach the frame end in both orders, along with restarts near both ends and direction flips in mid-frame. The default 768-gate build keeps the same structure, scaled through the generate loops.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    typedef enum logic {
        SCAN_UP   = 1'b0,
        SCAN_DOWN = 1'b1
    } scan_dir_e;

endpackage

// File: rtl/gsr_token_chain.sv
module gsr_token_chain
    import gsr_pkg::*;
#(
    parameter int STAGES = 769
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              start_i,
    input  logic              dir_i,
    output logic [STAGES-1:0] tok_o,
    output scan_dir_e         dir_o,
    output logic              done_o
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] tok;
        scan_dir_e         dir;
        logic              done;
    } chain_state_t;

    chain_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (shift_i) begin
            st_d.done = st_q.tok[LAST];
            if (start_i) begin
                st_d.tok    = '0;
                st_d.tok[0] = 1'b1;
                st_d.dir    = scan_dir_e'(dir_i);
            end else begin
                st_d.tok = {st_q.tok[LAST-1:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tok  <= '0;
            st_q.dir  <= SCAN_DOWN;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tok_o  = st_q.tok;
    assign dir_o  = st_q.dir;
    assign done_o = st_q.done;

    // R5: no strobe, token holds
    p_hold_no_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(tok_o));

    // R6: direction only changes at a start
    p_dir_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_i && start_i) |=> $stable(dir_o));

    // R2: start places token in stage 0 only
    p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && start_i) |=> (tok_o[0] && $onehot(tok_o)));

endmodule

// File: rtl/gsr_order_map.sv
module gsr_order_map
    import gsr_pkg::*;
#(
    parameter int N_GATES = 768
) (
    input  logic [N_GATES:0]   tok_i,
    input  scan_dir_e          dir_i,
    output logic               dummy_o,
    output logic [N_GATES-1:0] gate_o
);

    assign dummy_o = (dir_i == SCAN_DOWN) ? tok_i[0] : tok_i[N_GATES];

    for (genvar g = 0; g < N_GATES; g++) begin : g_map
        assign gate_o[g] = (dir_i == SCAN_DOWN) ? tok_i[g+1] : tok_i[N_GATES-1-g];
    end

endmodule

// File: rtl/gsr_enable_gate.sv
module gsr_enable_gate #(
    parameter int WIDTH = 769
) (
    input  logic [WIDTH-1:0] sel_i,
    input  logic             en_i,
    output logic [WIDTH-1:0] sel_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign sel_o[b] = sel_i[b] & en_i;
    end

endmodule

// File: rtl/gate_scan_shifter.sv
module gate_scan_shifter
    import gsr_pkg::*;
#(
    parameter int N_GATES = 768
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_i,
    input  logic               start_i,
    input  logic               dir_i,
    input  logic               enable_i,
    output logic               dummy_o,
    output logic [N_GATES-1:0] gate_o,
    output logic               frame_done_o
);

    localparam int STAGES = N_GATES + 1;

    logic [STAGES-1:0] tok_q;
    scan_dir_e         dir_q;
    logic              done_q;
    logic              dummy_raw;
    logic [N_GATES-1:0] gate_raw;
    logic [STAGES-1:0] sel_gated;

    gsr_token_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_i),
        .start_i (start_i),
        .dir_i   (dir_i),
        .tok_o   (tok_q),
        .dir_o   (dir_q),
        .done_o  (done_q)
    );

    gsr_order_map #(.N_GATES(N_GATES)) u_map (
        .tok_i   (tok_q),
        .dir_i   (dir_q),
        .dummy_o (dummy_raw),
        .gate_o  (gate_raw)
    );

    gsr_enable_gate #(.WIDTH(STAGES)) u_gate (
        .sel_i (({dummy_raw, gate_raw})),
        .en_i  (enable_i),
        .sel_o (sel_gated)
    );

    assign dummy_o      = sel_gated[N_GATES];
    assign gate_o       = sel_gated[N_GATES-1:0];
    assign frame_done_o = done_q;

    // R3: at most one row selected
    p_one_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dummy_o, gate_o}));

    // R4: any select requires the enable window
    p_sel_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dummy_o || (|gate_o)) |-> enable_i);

    // R7: frame-done lasts one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    // R1: reset leaves nothing selected
    always_comb begin
        if (!rst_n) begin
            a_reset_idle_r1: assert (!frame_done_o && !dummy_o && gate_o == '0);
        end
    end

endmodule

// File: tb/gate_scan_shifter_bench.sv
`timescale 1ns/1ps
module gate_scan_shifter_bench;

    localparam int N = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_i = 1'b0, start_i = 1'b0, dir_i = 1'b1, enable_i = 1'b0;
    logic dummy_o, frame_done_o;
    logic [N-1:0] gate_o;

    int checks = 0, errors = 0;
    int pos = -1;
    logic edir = 1'b1;
    logic edone = 1'b0;
    bit finished = 0;

    always #2 clk = ~clk;

    gate_scan_shifter #(.N_GATES(N)) u_gate_scan_shifter (
        .clk(clk), .rst_n(rst_n), .shift_i(shift_i), .start_i(start_i),
        .dir_i(dir_i), .enable_i(enable_i), .dummy_o(dummy_o),
        .gate_o(gate_o), .frame_done_o(frame_done_o)
    );

    function automatic logic [N+1:0] expect_vec(int p, logic d, logic en, logic dn);
        logic [N:0] sel = '0;
        if (p >= 0 && en) begin
            if (d) begin
                if (p == 0) sel[N] = 1'b1; else sel[p-1] = 1'b1;
            end else begin
                if (p == N) sel[N] = 1'b1; else sel[N-1-p] = 1'b1;
            end
        end
        return {dn, sel};
    endfunction

    task automatic check(string tag);
        logic [N+1:0] act, exp;
        act = {frame_done_o, dummy_o, gate_o};
        exp = expect_vec(pos, edir, enable_i, edone);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, model, sample at next negedge
    task automatic step(logic sh, logic st, logic d, logic en, string tag);
        shift_i = sh; start_i = st; dir_i = d; enable_i = en;
        @(posedge clk);
        edone = sh && (pos == N);
        if (sh) begin
            if (st) begin pos = 0; edir = d; end
            else if (pos >= 0) pos = (pos == N) ? -1 : pos + 1;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        enable_i = 1'b1;
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // downward full frame
        step(1, 1, 1, 1, "R2");
        for (int i = 0; i < N + 1; i++) step(1, 0, 1, 1, (i == N) ? "R7" : "R5");
        step(0, 0, 1, 1, "R7");
        // upward full frame with direction flipped mid-frame
        step(1, 1, 0, 1, "R2");
        step(0, 0, 0, 1, "R5");
        for (int i = 0; i < N + 1; i++) step(1, 0, i[0], 1, (i == N) ? "R7" : "R6");
        step(0, 0, 1, 1, "R7");
        // enable low hides but keeps token
        step(1, 1, 1, 0, "R4");
        step(1, 0, 1, 0, "R4");
        step(0, 0, 1, 1, "R4");
        // restart mid-frame in the other order
        step(1, 1, 0, 1, "R8");
        step(1, 0, 1, 1, "R8");

        for (int i = 0; i < 3000; i++) begin
            logic sh, st, d, en;
            sh = ($urandom % 3) != 0;
            st = ($urandom % 16) == 0;
            d  = $urandom % 2;
            en = ($urandom % 4) != 0;
            step(sh, st, d, en, !en ? "R4" : (sh && st) ? "R8" : sh ? "R5" : "R3");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule